// File: doc/BRIEF.md
# LCD common scan timing generator

This block produces the row-scan timing for a multiplexed dot-matrix character panel. A timer counts enabled oscillator ticks inside each row. When a row has run its full length, a row index moves on to the next common line. The index returns to line 0 once it has reached the row count that the active duty allows. The block drives a one-hot common-select vector, a row-latch strobe for the segment side, a frame-start pulse and a polarity flag that alternates on every frame.

The duty comes from two configuration bits, a tall-font bit and a two-line bit. The setting is sampled only when a frame wraps, so a new setting never cuts a frame short or makes it longer. A common line at or above the active row count is never selected. An invalid mix of both bits falls back to the sixteen-row duty.

Top module: `lcd_com_scan`

## Requirements
- R1: Each row lasts exactly 400 cycles in which `oscTick` is high. `rowLatch` is high for one cycle, during the cycle that carries the 400th tick of the row, and is low at every other time.
- R2: `comSel` is one-hot at all times, and bit i marks common row i. After each `rowLatch` that does not end the frame, the selected bit moves up by one position at the next clock edge.
- R3: The number of rows in a frame is set by the configuration inputs as follows. With `twoLine`=0 and `fontTall`=0 the frame has 8 rows. With `twoLine`=0 and `fontTall`=1 it has 11 rows. With `twoLine`=1 it has 16 rows and `fontTall` is ignored.
- R4: Every `comSel` bit at a position equal to or above the active row count stays 0 for the whole frame.
- R5: `frameStart` is high only in the same cycle as the `rowLatch` of the last active row. In the cycle after it, `comSel` equals 16'h0001.
- R6: `polarity` inverts at the clock edge that ends a `frameStart` cycle and holds its value at every other edge.
- R7: The configuration inputs are sampled only at the edge that ends a `frameStart` cycle. A change made during a frame has no effect on that frame's row count.
- R8: During and after reset, `comSel`=16'h0001, `rowLatch`=0, `frameStart`=0 and `polarity`=0. The first frame after reset has 8 rows, whatever the configuration inputs are.
- R9: Cycles with `oscTick` low do not advance the row timer, the row index, the polarity or the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| oscTick | input | 1 | Oscillator clock enable, one tick per scan clock |
| fontTall | input | 1 | Tall character font selection |
| twoLine | input | 1 | Two display lines selection |
| comSel | output | 16 | One-hot common line select |
| rowLatch | output | 1 | Strobe on the final tick of each row |
| frameStart | output | 1 | Strobe on the final tick of each frame |
| polarity | output | 1 | Drive polarity, alternates every frame |

## Verification
A wrong row timer shows up at the first `rowLatch`, which arrives early or late against the 400-tick count, so the fault is visible within one row. A wrong duty register or a wrong wrap compare becomes visible at the end of the first affected frame. There the row count, the highest selected common bit and the position of `frameStart` all differ from the values expected for that configuration. A polarity fault shows one cycle after any frame boundary. A sampling fault in the configuration shows as a frame whose length follows a mid-frame change.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  typedef enum logic [1:0] {
    DUTY_SHORT = 2'd0,
    DUTY_TALL  = 2'd1,
    DUTY_FULL  = 2'd2
  } dutySel_t;

  typedef struct packed {
    logic rowEnd;
    logic frameWrap;
  } scanStrobe_t;

  function automatic dutySel_t pickDuty(input logic fontTall, input logic twoLine);
    if (twoLine)       return DUTY_FULL;
    else if (fontTall) return DUTY_TALL;
    else               return DUTY_SHORT;
  endfunction

endpackage

// File: rtl/lcd_scan_ctrl.sv
module lcd_scan_ctrl
  import lcd_scan_pkg::*;
#(
  parameter int ROW_CLOCKS = 400,
  parameter int NUM_COMS   = 16,
  parameter int ROWS_SHORT = 8,
  parameter int ROWS_TALL  = 11,
  parameter int ROWS_FULL  = 16,
  localparam int CNT_W = $clog2(ROW_CLOCKS),
  localparam int IDX_W = $clog2(NUM_COMS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             oscTick,
  input  logic             fontTall,
  input  logic             twoLine,
  input  logic [IDX_W-1:0] rowIdx,
  output scanStrobe_t      strobe,
  output logic [IDX_W-1:0] activeLast
);

  localparam logic [CNT_W-1:0] ROW_LAST   = CNT_W'(ROW_CLOCKS - 1);
  localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(ROWS_SHORT - 1);
  localparam logic [IDX_W-1:0] LAST_TALL  = IDX_W'(ROWS_TALL - 1);
  localparam logic [IDX_W-1:0] LAST_FULL  = IDX_W'(ROWS_FULL - 1);

  logic [CNT_W-1:0] rowCnt;
  logic [IDX_W-1:0] lastRow;
  logic [IDX_W-1:0] nextLast;
  dutySel_t         nextSel;

  always_comb begin
    nextSel = pickDuty(fontTall, twoLine);
    case (nextSel)
      DUTY_TALL: nextLast = LAST_TALL;
      DUTY_FULL: nextLast = LAST_FULL;
      default:   nextLast = LAST_SHORT;
    endcase
  end

  always_comb begin
    strobe.rowEnd    = oscTick && (rowCnt == ROW_LAST);
    strobe.frameWrap = strobe.rowEnd && (rowIdx == lastRow);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rowCnt  <= '0;
      lastRow <= LAST_SHORT;
    end else if (oscTick) begin
      rowCnt <= strobe.rowEnd ? '0 : rowCnt + 1'b1;
      if (strobe.frameWrap) lastRow <= nextLast;
    end
  end

  assign activeLast = lastRow;

endmodule

// File: rtl/lcd_scan_dp.sv
module lcd_scan_dp
  import lcd_scan_pkg::*;
#(
  parameter int NUM_COMS = 16,
  localparam int IDX_W = $clog2(NUM_COMS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  scanStrobe_t         strobe,
  input  logic [IDX_W-1:0]    activeLast,
  output logic [IDX_W-1:0]    rowIdx,
  output logic [NUM_COMS-1:0] comSel,
  output logic                polarity
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rowIdx   <= '0;
      polarity <= 1'b0;
    end else if (strobe.frameWrap) begin
      rowIdx   <= '0;
      polarity <= ~polarity;
    end else if (strobe.rowEnd) begin
      rowIdx <= rowIdx + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_COMS; i++) begin : g_com
    assign comSel[i] = (rowIdx == IDX_W'(i)) && (IDX_W'(i) <= activeLast);
  end

endmodule

// File: rtl/lcd_com_scan.sv
module lcd_com_scan
  import lcd_scan_pkg::*;
#(
  parameter int ROW_CLOCKS = 400,
  parameter int NUM_COMS   = 16,
  parameter int ROWS_SHORT = 8,
  parameter int ROWS_TALL  = 11,
  parameter int ROWS_FULL  = 16,
  localparam int IDX_W = $clog2(NUM_COMS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                oscTick,
  input  logic                fontTall,
  input  logic                twoLine,
  output logic [NUM_COMS-1:0] comSel,
  output logic                rowLatch,
  output logic                frameStart,
  output logic                polarity
);

  scanStrobe_t      strobe;
  logic [IDX_W-1:0] rowIdx;
  logic [IDX_W-1:0] activeLast;

  lcd_scan_ctrl #(
    .ROW_CLOCKS(ROW_CLOCKS), .NUM_COMS(NUM_COMS),
    .ROWS_SHORT(ROWS_SHORT), .ROWS_TALL(ROWS_TALL), .ROWS_FULL(ROWS_FULL)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .oscTick(oscTick),
    .fontTall(fontTall), .twoLine(twoLine), .rowIdx(rowIdx),
    .strobe(strobe), .activeLast(activeLast)
  );

  lcd_scan_dp #(.NUM_COMS(NUM_COMS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .activeLast(activeLast),
    .rowIdx(rowIdx), .comSel(comSel), .polarity(polarity)
  );

  assign rowLatch   = strobe.rowEnd;
  assign frameStart = strobe.frameWrap;

endmodule

// File: rtl/lcd_com_scan_chk.sv
module lcd_com_scan_chk #(
  parameter int ROW_CLOCKS = 400,
  parameter int NUM_COMS   = 16,
  parameter int ROWS_SHORT = 8,
  parameter int ROWS_TALL  = 11,
  parameter int ROWS_FULL  = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                oscTick,
  input logic                fontTall,
  input logic                twoLine,
  input logic [NUM_COMS-1:0] comSel,
  input logic                rowLatch,
  input logic                frameStart,
  input logic                polarity
);

  localparam int TW = $clog2(ROW_CLOCKS) + 1;
  localparam int RW = $clog2(NUM_COMS) + 1;

  logic [TW-1:0] tickCnt;
  logic [RW-1:0] chkRows;
  logic [RW-1:0] cfgRows;

  always_comb begin
    if (twoLine)       cfgRows = RW'(ROWS_FULL);
    else if (fontTall) cfgRows = RW'(ROWS_TALL);
    else               cfgRows = RW'(ROWS_SHORT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tickCnt <= '0;
      chkRows <= RW'(ROWS_SHORT);
    end else begin
      if (rowLatch)     tickCnt <= '0;
      else if (oscTick) tickCnt <= tickCnt + 1'b1;
      if (frameStart)   chkRows <= cfgRows;
    end
  end

  AST_ROW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    rowLatch |-> (tickCnt == TW'(ROW_CLOCKS - 1))); // R1
  AST_LATCH_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    rowLatch |-> oscTick); // R9
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(comSel) == 1); // R2
  AST_SEL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (rowLatch && !frameStart) |=> (comSel == ($past(comSel) << 1))); // R2
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rowLatch |=> $stable(comSel)); // R9
  AST_NO_HIGH_COM: assert property (@(posedge clk) disable iff (!rst_n)
    (comSel >> chkRows) == '0); // R4
  AST_WRAP_AT_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rowLatch && comSel[chkRows - 1'b1]) |-> frameStart); // R3
  AST_FRAME_IN_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |-> rowLatch); // R5
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |=> comSel[0]); // R5
  AST_POL_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frameStart |=> (polarity != $past(polarity))); // R6
  AST_POL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    !frameStart |=> $stable(polarity)); // R6

endmodule

bind lcd_com_scan lcd_com_scan_chk #(
  .ROW_CLOCKS(ROW_CLOCKS), .NUM_COMS(NUM_COMS),
  .ROWS_SHORT(ROWS_SHORT), .ROWS_TALL(ROWS_TALL), .ROWS_FULL(ROWS_FULL)
) u_chk (.*);

// File: tb/sim_lcd_com_scan.sv
`timescale 1ns/1ps
module sim_lcd_com_scan;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        oscTick = 1'b0;
  logic        fontTall = 1'b0;
  logic        twoLine = 1'b1;
  logic [15:0] comSel;
  logic        rowLatch;
  logic        frameStart;
  logic        polarity;

  int  nTests = 0;
  int  nFail  = 0;
  logic expPol = 1'b0;

  always #2.5 clk = ~clk;

  lcd_com_scan u0 (
    .clk(clk), .rst_n(rst_n), .oscTick(oscTick),
    .fontTall(fontTall), .twoLine(twoLine),
    .comSel(comSel), .rowLatch(rowLatch),
    .frameStart(frameStart), .polarity(polarity)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  endtask

  // R8: reset values
  task automatic t_reset();
    rst_n = 1'b0; oscTick = 1'b1; fontTall = 1'b0; twoLine = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(comSel == 16'h0001, "R8", "reset comSel", comSel, 1);
    check(rowLatch == 1'b0, "R8", "reset rowLatch", rowLatch, 0);
    check(frameStart == 1'b0, "R8", "reset frameStart", frameStart, 0);
    check(polarity == 1'b0, "R8", "reset polarity", polarity, 0);
    @(posedge clk); #1;
    oscTick = 1'b0;
    rst_n = 1'b1;
  endtask

  // One frame: tick every 'period' cycles, optional configuration change at cycle chgAt
  task automatic t_frame(input int rows, input int period, input int chgAt,
                         input bit nFont, input bit nTwo, input string tag);
    int cyc = 0, latches = 0, expIdx = 0, gap = 0;
    int badSel = 0, badHigh = 0, badPol = 0, badGap = 0;
    bit done = 0, firstOk = 0, fsWithLatch = 0, hung = 0;
    while (!done) begin
      @(posedge clk); #1;
      cyc++; gap++;
      if (cyc == chgAt) begin fontTall = nFont; twoLine = nTwo; end
      oscTick = ((cyc % period) == 0);
      @(negedge clk);
      if (cyc == 1) firstOk = (comSel == 16'h0001);
      if (comSel != (16'h0001 << expIdx)) badSel++;
      if ((32'(comSel) >> rows) != 0) badHigh++;
      if (polarity != expPol) badPol++;
      if (rowLatch) begin
        if (gap != 400 * period) badGap++;
        gap = 0; latches++; expIdx++;
      end
      if (frameStart) begin done = 1; fsWithLatch = rowLatch; end
      if (cyc > 40000) begin done = 1; hung = 1; end
    end
    expPol = ~expPol;
    $display("[TB] frame %s: %0d cycles, %0d rows", tag, cyc, latches);
    check(!hung, "R5", {tag, " frame end seen"}, hung, 0);
    check(firstOk, "R5", {tag, " first row selected after wrap"}, firstOk, 1);
    check(cyc == rows * 400 * period, "R3", {tag, " cycles per frame"}, cyc, rows * 400 * period);
    check(latches == rows, "R3", {tag, " rows per frame"}, latches, rows);
    check(badGap == 0, "R1", {tag, " row length errors"}, badGap, 0);
    check(badSel == 0, "R2", {tag, " one-hot sequence errors"}, badSel, 0);
    check(badHigh == 0, "R4", {tag, " unused common selected"}, badHigh, 0);
    check(badPol == 0, "R6", {tag, " polarity errors"}, badPol, 0);
    check(fsWithLatch, "R5", {tag, " frameStart with rowLatch"}, fsWithLatch, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    t_reset();
    // R8/R7: first frame is 8 rows although 16-row config is applied
    t_frame(8, 1, 0, 1'b0, 1'b1, "post-reset");
    // R7: mid-frame change to tall font does not alter this 16-row frame
    t_frame(16, 1, 1000, 1'b1, 1'b0, "two-line");
    // R3: tall font gives 11 rows
    t_frame(11, 1, 100, 1'b0, 1'b0, "tall-font");
    // R9: half-rate ticks double the frame; R3 short font gives 8 rows
    t_frame(8, 2, 50, 1'b1, 1'b1, "short-half-rate");
    // R3: tall font with two lines falls back to 16 rows
    t_frame(16, 1, 0, 1'b1, 1'b1, "fallback");
    summary();
  end

endmodule